// File: doc/BRIEF.md
# Serial Character Receiver with Queued Interrupts

This block turns an asynchronous serial line into bytes. A fractional divider makes a tick at sixteen times the bit rate. The frame sampler uses that tick to find each character. Every good character goes into a sixteen-slot queue, which is read through a small register-style port.

Three interrupt causes are latched: the queue reaching its half-full mark, an idle timeout while characters wait in the queue, and a character lost to a full queue. Each cause has a raw flag. A mask routes the raw flags to one interrupt line, and writing a one to a bit of the clear input drops that flag.

Top module: `serial_rx_core`

## Requirements
- R1: The divisor is `div_int` plus `div_frac`/64. The oversampling tick averages one per divisor clock cycles, so a bit lasts 16 × divisor cycles: for example 32 cycles at 2.0, an alternating 40 at 2.5, and 48 at 3.0. A divisor of zero stops the tick.
- R2: A frame is a low start bit, then eight data bits with the least significant bit first, then a high stop bit. The line rests high. A complete frame with a high stop bit places its byte in the queue.
- R3: A low pulse on the line that lasts fewer than eight ticks is not taken as a start bit and stores nothing.
- R4: A frame whose stop bit samples low is dropped. The receiver then waits for the line to go high before it looks for a new start bit.
- R5: The queue holds 16 bytes in arrival order. `rd_data` shows the oldest byte, and a cycle with `rd_en` high removes it. A read while the queue is empty changes nothing.
- R6: `fifo_empty` is high exactly when the queue holds no bytes. `fifo_full` is high exactly when it holds 16 bytes.
- R7: A byte that completes while the queue is full, with no read in that cycle, is discarded and the stored bytes are kept. It sets raw flag bit 2 (`overrun_flag`), which stays set until a clear write with bit 2 high.
- R8: Raw flag bit 0 sets when the queue fill rises from 7 to 8 entries. It is cleared only by a clear write with bit 0 high.
- R9: Raw flag bit 1 sets when the queue is not empty and 32 bit periods (512 ticks) have passed since the last confirmed start bit or the last read. It fires once per quiet stretch and is cleared by a clear write with bit 1 high.
- R10: `irq` is high when any raw flag is set and its bit in `irq_mask` is also set.
- R11: After reset the queue is empty, the queue is not full, all raw flags are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial line, idle high |
| div_int | input | 16 | Integer part of the divisor |
| div_frac | input | 6 | Fractional part of the divisor, in sixty-fourths |
| rd_en | input | 1 | Remove the oldest byte this cycle |
| rd_data | output | 8 | Oldest byte in the queue |
| fifo_full | output | 1 | Queue holds 16 bytes |
| fifo_empty | output | 1 | Queue holds no bytes |
| overrun_flag | output | 1 | A byte was lost to a full queue (raw bit 2) |
| irq_mask | input | 3 | Enable per raw flag: bit 0 level, bit 1 timeout, bit 2 overrun |
| irq_clear | input | 3 | Write-one-to-clear pulse per raw flag |
| irq_raw | output | 3 | Latched raw interrupt flags |
| irq | output | 1 | Masked interrupt request |

## Verification
An error in the divider or in the sampler's tick counts shows up at the ports within one frame. The byte read back is wrong, or it never arrives. An error in a queue pointer shows up at the first read after a wrap, when the order breaks or the empty and full flags stop matching the number of bytes sent. The timeout counter is only seen through raw bit 1, so the bench samples that bit a few bit periods before and a few bit periods after the expected firing point. This catches a counter that fires early, fires late, or is not restarted by a read.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int OSR = 16;

  localparam int IRQ_LEVEL   = 0;
  localparam int IRQ_TIMEOUT = 1;
  localparam int IRQ_OVERRUN = 2;
  localparam int IRQ_W       = 3;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_e;

  // ticks in an idle window measured in bit periods
  function automatic int quiet_ticks(input int bit_periods);
    return bit_periods * OSR;
  endfunction

  // next ring index with wrap at depth
  function automatic int ring_next(input int idx, input int depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/rx_baud_gen.sv
module rx_baud_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);
  localparam int TOT_W = INT_W + FRAC_W;
  localparam int ACC_W = TOT_W + 1;
  localparam logic [ACC_W-1:0] UNIT = ACC_W'(1) << FRAC_W;

  logic [TOT_W-1:0] total;
  logic [ACC_W-1:0] acc_q, acc_sum, total_ext;
  logic             hit;

  assign total     = {div_int, div_frac};
  assign total_ext = {1'b0, total};
  assign acc_sum   = acc_q + UNIT;
  assign hit       = (total != '0) && (acc_sum >= total_ext);
  assign tick      = hit;

  always_ff @(posedge clk) begin
    if (!rst_n)             acc_q <= '0;
    else if (total == '0)   acc_q <= '0;
    else if (hit)           acc_q <= acc_sum - total_ext;
    else                    acc_q <= acc_sum;
  end

  // R1: with a divisor of at least two, ticks never come back to back
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && total >= TOT_W'(2 << FRAC_W)) |=> (!tick || total != $past(total)));

endmodule

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_s,
  output logic              char_valid,
  output logic [DATA_W-1:0] char_data,
  output logic              start_seen
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF  = OSR / 2;

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;

  assign char_data = shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      shift_q    <= '0;
      char_valid <= 1'b0;
      start_seen <= 1'b0;
    end else begin
      char_valid <= 1'b0;
      start_seen <= 1'b0;
      if (state_q == RX_WAIT_HIGH) begin
        if (line_s) state_q <= RX_IDLE;
      end else if (tick) begin
        case (state_q)
          RX_IDLE: begin
            if (!line_s) begin
              state_q <= RX_START;
              cnt_q   <= CNT_W'(1);
            end
          end
          RX_START: begin
            if (cnt_q == CNT_W'(HALF - 1)) begin
              if (!line_s) begin
                state_q    <= RX_DATA;
                cnt_q      <= '0;
                idx_q      <= '0;
                start_seen <= 1'b1;
              end else begin
                state_q <= RX_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == CNT_W'(OSR - 1)) begin
              cnt_q   <= '0;
              shift_q <= {line_s, shift_q[DATA_W-1:1]};
              if (idx_q == IDX_W'(DATA_W - 1)) state_q <= RX_STOP;
              else                             idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == CNT_W'(OSR - 1)) begin
              cnt_q <= '0;
              if (line_s) begin
                char_valid <= 1'b1;
                state_q    <= RX_IDLE;
              end else begin
                state_q <= RX_WAIT_HIGH;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  // R2: a byte is delivered only on the way back to idle
  a_r2_valid_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> (state_q == RX_IDLE));

  // R3: a confirmed start always leads into data sampling
  a_r3_start_enters_data: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |-> (state_q == RX_DATA && idx_q == '0));

  // R4: a low stop bit never produces a byte
  a_r4_no_byte_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_WAIT_HIGH) |-> !char_valid);

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import serial_rx_pkg::*;
#(
  parameter int W      = 8,
  parameter int DEPTH  = 16,
  parameter int THRESH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       overrun_evt,
  output logic                       level_evt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q, cnt_next;
  logic          do_push, do_pop;

  assign empty       = (cnt_q == '0);
  assign full        = (cnt_q == CW'(DEPTH));
  assign count       = cnt_q;
  assign rdata       = mem_q[rp_q];
  assign do_pop      = pop && !empty;
  assign do_push     = push && (!full || do_pop);
  assign overrun_evt = push && full && !do_pop;
  assign cnt_next    = cnt_q + CW'(do_push) - CW'(do_pop);
  assign level_evt   = (cnt_q < CW'(THRESH)) && (cnt_next >= CW'(THRESH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_next;
      if (do_push) wp_q <= AW'(ring_next(int'(wp_q), DEPTH));
      if (do_pop)  rp_q <= AW'(ring_next(int'(rp_q), DEPTH));
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && wp_q == AW'(g)) mem_q[g] <= wdata;
    end
  end

  // R5: fill never exceeds capacity
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R6: full and empty are never seen together
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R7: a lost byte leaves the queue full and its head unchanged
  a_r7_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> (full && $stable(rp_q)));

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int DIV_INT_W    = 16,
  parameter int DIV_FRAC_W   = 6,
  parameter int DATA_W       = 8,
  parameter int DEPTH        = 16,
  parameter int LEVEL_MARK   = 8,
  parameter int TIMEOUT_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rxd,
  input  logic [DIV_INT_W-1:0]  div_int,
  input  logic [DIV_FRAC_W-1:0] div_frac,
  input  logic                  rd_en,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  fifo_full,
  output logic                  fifo_empty,
  output logic                  overrun_flag,
  input  logic [IRQ_W-1:0]      irq_mask,
  input  logic [IRQ_W-1:0]      irq_clear,
  output logic [IRQ_W-1:0]      irq_raw,
  output logic                  irq
);
  localparam int TO_LIMIT = quiet_ticks(TIMEOUT_BITS);
  localparam int TW       = $clog2(TO_LIMIT + 1);
  localparam int CW       = $clog2(DEPTH + 1);

  logic              sync1_q, sync2_q;
  logic              tick;
  logic              char_valid, start_seen;
  logic [DATA_W-1:0] char_data;
  logic [CW-1:0]     fill;
  logic              overrun_evt, level_evt, timeout_evt, rd_accept;
  logic [TW-1:0]     quiet_q;
  logic [IRQ_W-1:0]  raw_q, evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= rxd;
      sync2_q <= sync1_q;
    end
  end

  rx_baud_gen #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div_int(div_int), .div_frac(div_frac), .tick(tick)
  );

  rx_frame_sampler #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_s(sync2_q),
    .char_valid(char_valid), .char_data(char_data), .start_seen(start_seen)
  );

  rx_char_fifo #(.W(DATA_W), .DEPTH(DEPTH), .THRESH(LEVEL_MARK)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(char_valid), .wdata(char_data), .pop(rd_en),
    .rdata(rd_data), .full(fifo_full), .empty(fifo_empty), .count(fill),
    .overrun_evt(overrun_evt), .level_evt(level_evt)
  );

  assign rd_accept = rd_en && !fifo_empty;

  // idle timer in ticks, saturating so it fires once per quiet stretch
  always_ff @(posedge clk) begin
    if (!rst_n)                      quiet_q <= '0;
    else if (start_seen || rd_accept) quiet_q <= '0;
    else if (tick && quiet_q != TW'(TO_LIMIT)) quiet_q <= quiet_q + 1'b1;
  end

  assign timeout_evt = tick && (quiet_q == TW'(TO_LIMIT - 1)) && !fifo_empty
                       && !start_seen && !rd_accept;

  assign evt[IRQ_LEVEL]   = level_evt;
  assign evt[IRQ_TIMEOUT] = timeout_evt;
  assign evt[IRQ_OVERRUN] = overrun_evt;

  for (genvar g = 0; g < IRQ_W; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)       raw_q[g] <= 1'b0;
      else if (evt[g])  raw_q[g] <= 1'b1;
      else if (irq_clear[g]) raw_q[g] <= 1'b0;
    end
  end

  assign irq_raw      = raw_q;
  assign overrun_flag = raw_q[IRQ_OVERRUN];
  assign irq          = |(raw_q & irq_mask);

  // R7: the overrun flag only falls through a clear write
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q[IRQ_OVERRUN] && !irq_clear[IRQ_OVERRUN]) |=> raw_q[IRQ_OVERRUN]);

  // R8: the level cause coincides with the queue reaching its mark
  a_r8_level_mark: assert property (@(posedge clk) disable iff (!rst_n)
    level_evt |=> (fill == CW'(LEVEL_MARK)));

  // R9: timeout never fires on an empty queue, nor right after a read
  a_r9_timeout_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q[IRQ_TIMEOUT]) |-> (!$past(fifo_empty) && !$past(rd_accept)));

  // R10: the request needs at least one enabled cause
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|irq_mask));

endmodule

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] div_int = 16'd2;
  logic [5:0]  div_frac = 6'd0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        fifo_full, fifo_empty, overrun_flag;
  logic [2:0]  irq_mask = 3'b000;
  logic [2:0]  irq_clear = 3'b000;
  logic [2:0]  irq_raw;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit auto_drain = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  serial_rx_core uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .div_int(div_int), .div_frac(div_frac),
    .rd_en(rd_en), .rd_data(rd_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .overrun_flag(overrun_flag), .irq_mask(irq_mask), .irq_clear(irq_clear),
    .irq_raw(irq_raw), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    @(posedge clk); #2; rxd = v;
    repeat (n - 1) @(posedge clk);
  endtask

  // drive one frame; stop_v selects a good or a bad stop bit
  task automatic send(input logic [7:0] b, input int bitclk, input logic stop_v,
                      input bit expect_it);
    if (expect_it) exp_q.push_back(b);
    hold(1'b0, bitclk);
    for (int i = 0; i < 8; i++) hold(b[i], bitclk);
    hold(stop_v, bitclk);
    if (!stop_v) hold(1'b1, bitclk);
    repeat (4) @(posedge clk);
  endtask

  task automatic wait_bits(input int n);
    repeat (n * 32) @(posedge clk);
  endtask

  task automatic clear_flags(input logic [2:0] bits);
    @(negedge clk); irq_clear = bits;
    @(negedge clk); irq_clear = 3'b000;
  endtask

  task automatic read_one(input string req);
    logic [7:0] e;
    @(negedge clk);
    if (exp_q.size() == 0) begin
      check(req, int'(rd_data), -1);
    end else begin
      e = exp_q.pop_front();
      check(req, int'(rd_data), int'(e));
    end
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // scoreboard monitor: drains the queue whenever auto_drain is on
  initial begin
    forever begin
      @(negedge clk);
      if (auto_drain && !fifo_empty && !rd_en) begin
        if (exp_q.size() == 0) check("R2 unexpected byte", int'(rd_data), -1);
        else check("R2 byte value", int'(rd_data), int'(exp_q.pop_front()));
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R11 empty", fifo_empty, 1);
    check("R11 full", fifo_full, 0);
    check("R11 raw", irq_raw, 0);
    check("R11 irq", irq, 0);

    // R2: several patterns at divisor 2.0
    auto_drain = 1'b1;
    send(8'hCC, 32, 1'b1, 1); send(8'h00, 32, 1'b1, 1);
    send(8'hFF, 32, 1'b1, 1); send(8'hA5, 32, 1'b1, 1);
    repeat (10) @(posedge clk);
    check("R2 all drained", exp_q.size(), 0);

    // R1: fractional divisor 2.5 gives 40-cycle bits, 3.0 gives 48
    div_frac = 6'd32;
    send(8'h5A, 40, 1'b1, 1); send(8'h81, 40, 1'b1, 1);
    div_int = 16'd3; div_frac = 6'd0;
    send(8'h3C, 48, 1'b1, 1);
    div_int = 16'd2;
    repeat (10) @(posedge clk);
    check("R1 fractional rates drained", exp_q.size(), 0);
    wait_bits(40);
    check("R9 no timeout on empty queue", irq_raw, 0);
    auto_drain = 1'b0;

    // R3: short low glitch
    hold(1'b0, 10); hold(1'b1, 2);
    wait_bits(12);
    check("R3 glitch ignored", fifo_empty, 1);

    // R4: low stop bit drops the frame, the next frame is still taken
    send(8'h99, 32, 1'b0, 0);
    wait_bits(2);
    check("R4 bad stop dropped", fifo_empty, 1);
    send(8'h42, 32, 1'b1, 1);
    read_one("R4 recovery byte");

    // R8, R10, R6, R7: fill the queue
    for (int i = 0; i < 7; i++) send(8'(8'h10 + i), 32, 1'b1, 1);
    check("R8 below mark", irq_raw[0], 0);
    send(8'h17, 32, 1'b1, 1);
    check("R8 at mark", irq_raw[0], 1);
    irq_mask = 3'b001; @(negedge clk);
    check("R10 masked on", irq, 1);
    irq_mask = 3'b110; @(negedge clk);
    check("R10 masked off", irq, 0);
    clear_flags(3'b001);
    check("R8 cleared", irq_raw[0], 0);
    for (int i = 0; i < 8; i++) send(8'(8'hE0 + i), 32, 1'b1, 1);
    check("R6 full", fifo_full, 1);
    check("R7 no overrun yet", overrun_flag, 0);
    send(8'h5F, 32, 1'b1, 0);
    check("R7 overrun set", overrun_flag, 1);
    check("R7 still full", fifo_full, 1);
    clear_flags(3'b011);
    check("R7 sticky", overrun_flag, 1);
    for (int i = 0; i < 16; i++) read_one("R5 order");
    @(negedge clk);
    check("R6 empty after drain", fifo_empty, 1);
    @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    send(8'h77, 32, 1'b1, 1);
    read_one("R5 read on empty ignored");
    @(negedge clk);
    check("R5 single entry", fifo_empty, 1);
    clear_flags(3'b100);
    check("R7 cleared", overrun_flag, 0);

    // R9: idle timeout
    clear_flags(3'b111);
    send(8'h11, 32, 1'b1, 1);
    wait_bits(20);
    check("R9 not yet", irq_raw[1], 0);
    wait_bits(5);
    check("R9 fired", irq_raw[1], 1);
    irq_mask = 3'b010; @(negedge clk);
    check("R10 timeout irq", irq, 1);
    clear_flags(3'b010);
    wait_bits(40);
    check("R9 fires once", irq_raw[1], 0);
    send(8'h22, 32, 1'b1, 1);
    wait_bits(15);
    read_one("R9 read restarts timer");
    wait_bits(28);
    check("R9 restarted by read", irq_raw[1], 0);
    wait_bits(8);
    check("R9 fired after read", irq_raw[1], 1);
    read_one("R9 last byte");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule